// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block tracks the coherence state of every line in one private, direct-mapped cache that sits on a shared snooping bus. It stores a tag and a two-bit coherence state per line. It decides, for each processor read or write, whether the access can finish locally or needs a bus transaction. It also answers transactions from other caches that it observes on the bus. The data array, memory, arbitration and victim selection belong to neighbouring blocks.

The processor presents a request and holds it until acknowledged. A hit that needs no bus traffic is acknowledged in the same cycle. Any other request raises a stall and presents a bus operation with its address. After the arbiter grants the bus, the operation stays fixed until the bus reports completion. In that completion cycle the line state is written and the processor is acknowledged.

Snooped operations get combinational responses in the cycle they appear: a shared flag, a data-supply strobe and a write-back strobe. The line state is updated at the following clock edge.

Top module: `mesi_ctrl`

## Requirements
- R1: Line states are encoded in two bits as Invalid=00, Shared=01, Exclusive=10, Modified=11. Reset puts every line in Invalid, so a snoop to any address then gets no response.
- R2: A read that misses presents bus operation 01 (read). The line is filled as Exclusive if `bus_shared` is low in the completion cycle, and as Shared otherwise.
- R3: A read that hits a Shared, Exclusive or Modified line is acknowledged in the cycle it is presented. It raises no bus request and leaves the state unchanged.
- R4: A write that misses presents bus operation 10 (read-for-ownership) and leaves the line Modified.
- R5: A write to a Shared line presents bus operation 11 (invalidate) and leaves the line Modified.
- R6: A write to an Exclusive or Modified line is acknowledged in the cycle it is presented, with no bus request, and leaves the line Modified.
- R7: A snooped read (`snp_op`=01) to a held line asserts `snp_shared`. Invalid and Shared lines stay as they are. An Exclusive line asserts `snp_supply` and becomes Shared. A Modified line asserts `snp_supply` and `snp_wb` and becomes Shared.
- R8: A snooped read-for-ownership (`snp_op`=10) moves a Shared or Exclusive line to Invalid without supplying data. A Modified line asserts `snp_supply` and then becomes Invalid.
- R9: A snooped invalidate (`snp_op`=11) moves a held line to Invalid without any response strobe.
- R10: While a request needs the bus, `cpu_stall` is high and `bus_req` is high with a nonzero `bus_op`. After `bus_gnt`, the operation stays unchanged until `bus_done`. `cpu_ack` and the state update happen in the `bus_done` cycle.
- R11: A snoop to the exact address of a pending processor request takes effect first. In that cycle the request is neither acknowledged nor shown on the bus. In the next cycle it is re-evaluated from the new state, so a pending invalidate becomes a read-for-ownership.
- R12: An address whose index matches a stored line but whose tag differs is a miss. Filling it replaces the stored tag, and snoops to the old address then get no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | TAG_W+IDX_W | Line address (index in the low bits) |
| cpu_ack | output | 1 | Request completed this cycle |
| cpu_stall | output | 1 | Request pending and not completed |
| bus_req | output | 1 | Bus operation requested |
| bus_op | output | 2 | 01 read, 10 read-for-ownership, 11 invalidate |
| bus_addr | output | TAG_W+IDX_W | Address of the bus operation |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_done | input | 1 | Granted operation completes this cycle |
| bus_shared | input | 1 | Another cache holds the line (read completion) |
| snp_op | input | 2 | Observed operation from another cache, 00 none |
| snp_addr | input | TAG_W+IDX_W | Address of the observed operation |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache supplies the line's data |
| snp_wb | output | 1 | Line must be written back to memory |

## Verification
The assertions check on every cycle that a write-back strobe only appears together with a data supply on a snooped read, and that a bus request always carries an operation. They also check that a granted operation keeps its encoding, that a completion acknowledges the processor, and that reset leaves no snoop response. Only the bench scenarios can show the state-by-state transitions. These include the Exclusive fill versus the Shared fill, the silent upgrade of Exclusive to Modified, and the switch of a pending invalidate to a read-for-ownership after a colliding snoop. They also include the tag replacement at a shared index. The bench observes each of these through later requests and snoop responses.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } mesi_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_RD   = 2'b01,
        OP_RFO  = 2'b10,
        OP_INV  = 2'b11
    } busop_t;

    typedef struct packed {
        logic  shared;
        logic  supply;
        logic  wb;
        mesi_t next;
    } snp_rsp_t;

    // Response and next state of a held line when another cache's operation is seen
    function automatic snp_rsp_t snoop_react(mesi_t st, busop_t op);
        snp_rsp_t r;
        r.shared = 1'b0;
        r.supply = 1'b0;
        r.wb     = 1'b0;
        r.next   = st;
        if (st != ST_I) begin
            unique case (op)
                OP_RD: begin
                    r.shared = 1'b1;
                    r.supply = (st == ST_E) || (st == ST_M);
                    r.wb     = (st == ST_M);
                    r.next   = (st == ST_S) ? ST_S : ST_S;
                end
                OP_RFO: begin
                    r.supply = (st == ST_M);
                    r.next   = ST_I;
                end
                OP_INV: begin
                    r.next   = ST_I;
                end
                default: r.next = st;
            endcase
        end
        return r;
    endfunction

    // Bus operation a processor access needs from the current line state
    function automatic busop_t needed_op(mesi_t st, logic we);
        busop_t op;
        if (!we) begin
            op = (st == ST_I) ? OP_RD : OP_NONE;
        end else begin
            unique case (st)
                ST_I:    op = OP_RFO;
                ST_S:    op = OP_INV;
                default: op = OP_NONE;
            endcase
        end
        return op;
    endfunction

    // Final state once a bus operation of ours completes
    function automatic mesi_t fill_state(busop_t op, logic others_hold);
        if (op == OP_RD) begin
            return others_hold ? ST_S : ST_E;
        end
        return ST_M;
    endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] cpu_idx,
    output mesi_t            cpu_st,
    output logic [TAG_W-1:0] cpu_tag,
    input  logic [IDX_W-1:0] snp_idx,
    output mesi_t            snp_st,
    output logic [TAG_W-1:0] snp_tag,
    input  logic             loc_upd,
    input  logic [TAG_W-1:0] loc_tag,
    input  mesi_t            loc_st,
    input  logic             snp_upd,
    input  mesi_t            snp_new
);
    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        mesi_t            st;
    } line_t;

    line_t lines [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q.tag <= '0;
                q.st  <= ST_I;
            end else if (loc_upd && (cpu_idx == IDX_W'(g))) begin
                // the local completion wins over a snoop in the same cycle
                q.tag <= loc_tag;
                q.st  <= loc_st;
            end else if (snp_upd && (snp_idx == IDX_W'(g))) begin
                q.st  <= snp_new;
            end
        end
        assign lines[g] = q;
    end

    assign cpu_st  = lines[cpu_idx].st;
    assign cpu_tag = lines[cpu_idx].tag;
    assign snp_st  = lines[snp_idx].st;
    assign snp_tag = lines[snp_idx].tag;

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic [1:0]       op_in,
    input  logic [TAG_W-1:0] addr_tag,
    input  mesi_t            line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             rsp_shared,
    output logic             rsp_supply,
    output logic             rsp_wb,
    output logic             upd,
    output mesi_t            upd_st
);
    mesi_t    eff_st;
    snp_rsp_t rsp;

    always_comb begin
        eff_st     = (line_tag == addr_tag) ? line_st : ST_I;
        rsp        = snoop_react(eff_st, busop_t'(op_in));
        rsp_shared = rsp.shared;
        rsp_supply = rsp.supply;
        rsp_wb     = rsp.wb;
        upd        = (eff_st != ST_I) && (rsp.next != eff_st);
        upd_st     = rsp.next;
    end

endmodule

// File: rtl/mesi_req_ctrl.sv
module mesi_req_ctrl
    import mesi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_req,
    input  logic       cpu_we,
    input  mesi_t      cur_st,
    input  logic       collide,
    input  logic       bus_gnt,
    input  logic       bus_done,
    input  logic       bus_shared,
    output logic       cpu_ack,
    output logic       cpu_stall,
    output logic       bus_req,
    output logic [1:0] bus_op,
    output logic       loc_upd,
    output mesi_t      loc_st
);
    typedef enum logic {PH_IDLE, PH_XFER} phase_t;

    phase_t phase_q;
    busop_t held_q;
    busop_t want;

    always_comb begin
        want    = needed_op(cur_st, cpu_we);
        cpu_ack = 1'b0;
        bus_req = 1'b0;
        bus_op  = OP_NONE;
        loc_upd = 1'b0;
        loc_st  = ST_M;
        if (phase_q == PH_XFER) begin
            bus_req = 1'b1;
            bus_op  = held_q;
            if (bus_done) begin
                cpu_ack = 1'b1;
                loc_upd = 1'b1;
                loc_st  = fill_state(held_q, bus_shared);
            end
        end else if (cpu_req && !collide) begin
            if (want == OP_NONE) begin
                cpu_ack = 1'b1;
                loc_upd = cpu_we;
                loc_st  = ST_M;
            end else begin
                bus_req = 1'b1;
                bus_op  = want;
            end
        end
        cpu_stall = cpu_req && !cpu_ack;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            held_q  <= OP_NONE;
        end else if (phase_q == PH_IDLE) begin
            if (bus_req && bus_gnt) begin
                phase_q <= PH_XFER;
                held_q  <= want;
            end
        end else if (bus_done) begin
            phase_q <= PH_IDLE;
        end
    end

endmodule

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
    import mesi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cpu_req,
    input  logic                   cpu_we,
    input  logic [TAG_W+IDX_W-1:0] cpu_addr,
    output logic                   cpu_ack,
    output logic                   cpu_stall,
    output logic                   bus_req,
    output logic [1:0]             bus_op,
    output logic [TAG_W+IDX_W-1:0] bus_addr,
    input  logic                   bus_gnt,
    input  logic                   bus_done,
    input  logic                   bus_shared,
    input  logic [1:0]             snp_op,
    input  logic [TAG_W+IDX_W-1:0] snp_addr,
    output logic                   snp_shared,
    output logic                   snp_supply,
    output logic                   snp_wb
);
    localparam int ADDR_W = TAG_W + IDX_W;

    logic [IDX_W-1:0] cpu_idx, snp_idx;
    logic [TAG_W-1:0] cpu_tag_in, snp_tag_in;
    mesi_t            cpu_line_st, snp_line_st, cpu_eff_st;
    logic [TAG_W-1:0] cpu_line_tag, snp_line_tag;
    logic             loc_upd, snp_upd, collide;
    mesi_t            loc_st, snp_new;

    assign cpu_idx    = cpu_addr[IDX_W-1:0];
    assign cpu_tag_in = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx    = snp_addr[IDX_W-1:0];
    assign snp_tag_in = snp_addr[ADDR_W-1:IDX_W];
    assign bus_addr   = cpu_addr;

    assign cpu_eff_st = (cpu_line_tag == cpu_tag_in) ? cpu_line_st : ST_I;
    assign collide    = cpu_req && (snp_op != 2'b00) && (snp_addr == cpu_addr);

    mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .cpu_idx (cpu_idx),
        .cpu_st  (cpu_line_st),
        .cpu_tag (cpu_line_tag),
        .snp_idx (snp_idx),
        .snp_st  (snp_line_st),
        .snp_tag (snp_line_tag),
        .loc_upd (loc_upd),
        .loc_tag (cpu_tag_in),
        .loc_st  (loc_st),
        .snp_upd (snp_upd),
        .snp_new (snp_new)
    );

    mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
        .op_in      (snp_op),
        .addr_tag   (snp_tag_in),
        .line_st    (snp_line_st),
        .line_tag   (snp_line_tag),
        .rsp_shared (snp_shared),
        .rsp_supply (snp_supply),
        .rsp_wb     (snp_wb),
        .upd        (snp_upd),
        .upd_st     (snp_new)
    );

    mesi_req_ctrl u_req (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cur_st     (cpu_eff_st),
        .collide    (collide),
        .bus_gnt    (bus_gnt),
        .bus_done   (bus_done),
        .bus_shared (bus_shared),
        .cpu_ack    (cpu_ack),
        .cpu_stall  (cpu_stall),
        .bus_req    (bus_req),
        .bus_op     (bus_op),
        .loc_upd    (loc_upd),
        .loc_st     (loc_st)
    );

endmodule

// File: rtl/mesi_ctrl_chk.sv
module mesi_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cpu_ack,
    input logic       bus_req,
    input logic [1:0] bus_op,
    input logic       bus_gnt,
    input logic       bus_done,
    input logic [1:0] snp_op,
    input logic       snp_shared,
    input logic       snp_supply,
    input logic       snp_wb
);
    assert_wb_with_supply_R7: assert property (@(posedge clk) disable iff (rst)
        snp_wb |-> (snp_supply && snp_op == 2'b01));

    assert_req_carries_op_R10: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_op != 2'b00));

    assert_granted_op_held_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_gnt && !bus_done) |=> (bus_req && bus_op == $past(bus_op)));

    assert_done_acks_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_req && bus_gnt) && bus_done) |-> cpu_ack);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!snp_shared && !snp_supply && !cpu_ack));

endmodule

bind mesi_ctrl mesi_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_ack    (cpu_ack),
    .bus_req    (bus_req),
    .bus_op     (bus_op),
    .bus_gnt    (bus_gnt),
    .bus_done   (bus_done),
    .snp_op     (snp_op),
    .snp_shared (snp_shared),
    .snp_supply (snp_supply),
    .snp_wb     (snp_wb)
);

// File: tb/sim_mesi_ctrl.sv
module sim_mesi_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [8:0] cpu_addr = '0, snp_addr = '0;
    logic       bus_gnt = 1'b0, bus_done = 1'b0, bus_shared = 1'b0;
    logic [1:0] snp_op = 2'b00;
    logic       cpu_ack, cpu_stall, bus_req;
    logic [1:0] bus_op;
    logic [8:0] bus_addr;
    logic       snp_shared, snp_supply, snp_wb;

    int checks = 0;
    int errors = 0;
    int model [int];   // address -> state (absent = Invalid)

    always #2 clk = ~clk;   // 250 MHz

    mesi_ctrl u0 (.*);

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_st(input int a);
        return model.exists(a) ? model[a] : 0;
    endfunction

    task automatic ref_set(input int a, input int s);
        int victims[$];
        foreach (model[k]) if ((k % 8) == (a % 8)) victims.push_back(k);
        foreach (victims[i]) model.delete(victims[i]);
        if (s != 0) model[a] = s;
    endtask

    // expected snoop reaction: {shared, supply, wb} and next state
    function automatic int exp_rsp(input int st, input int op);
        if (st == 0 || op == 0) return 0;
        if (op == 1) return 4 + ((st >= 2) ? 2 : 0) + ((st == 3) ? 1 : 0);
        if (op == 2) return (st == 3) ? 2 : 0;
        return 0;
    endfunction

    function automatic int exp_next(input int st, input int op);
        if (st == 0 || op == 0) return st;
        if (op == 1) return 1;
        return 0;
    endfunction

    function automatic int exp_op(input int st, input bit we);
        if (!we) return (st == 0) ? 1 : 0;
        if (st == 0) return 2;
        if (st == 1) return 3;
        return 0;
    endfunction

    task automatic check_snoop(input int st, input int op, input string req);
        int e;
        e = exp_rsp(st, op);
        chk({snp_shared, snp_supply, snp_wb} == 3'(e), req, "snoop response", int'({snp_shared, snp_supply, snp_wb}), e);
    endtask

    task automatic probe(input int op, input int a, input string req);
        int st;
        @(negedge clk);
        snp_op = 2'(op); snp_addr = 9'(a);
        #1;
        st = ref_st(a);
        check_snoop(st, op, req);
        @(posedge clk);
        if (st != 0) ref_set(a, exp_next(st, op));
        @(negedge clk);
        snp_op = 2'b00;
    endtask

    task automatic cpu_op(input bit we, input int a, input int sop, input int gdelay, input bit shin, input string req);
        int cyc = 0, waited = 0, st, want, newst = 0, held = 0;
        bit xfer = 0, xfer_nx = 0, done = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = 9'(a);
        while (!done) begin
            snp_op = (cyc == 0) ? 2'(sop) : 2'b00; snp_addr = 9'(a);
            bus_done = xfer; bus_shared = xfer ? shin : 1'b0; bus_gnt = 1'b0;
            #1;
            st = ref_st(a);
            check_snoop(st, int'(snp_op), req);
            if (xfer) begin
                chk(cpu_ack && bus_req && bus_op == 2'(held), req, "completion ack/op", int'(bus_op), held);
                newst = (held == 1) ? (shin ? 1 : 2) : 3;
                done = 1;
            end else if (snp_op != 2'b00) begin
                chk(!cpu_ack && !bus_req && cpu_stall, req, "collision hold (R11)", int'({cpu_ack, bus_req}), 0);
            end else begin
                want = exp_op(st, we);
                if (want == 0) begin
                    chk(cpu_ack && !bus_req && !cpu_stall, req, "local completion", int'({cpu_ack, bus_req}), 2);
                    newst = we ? 3 : st;
                    done = 1;
                end else begin
                    chk(bus_req && bus_op == 2'(want) && cpu_stall && !cpu_ack, req, "bus op", int'(bus_op), want);
                    chk(bus_addr == 9'(a), req, "bus addr", int'(bus_addr), a);
                    if (waited >= gdelay) begin bus_gnt = 1'b1; held = want; xfer_nx = 1; end
                    else waited++;
                end
            end
            @(posedge clk);
            if (snp_op != 2'b00 && st != 0) ref_set(a, exp_next(st, int'(snp_op)));
            if (done) ref_set(a, newst);
            xfer = xfer_nx;
            cyc++;
            if (!done) @(negedge clk);
        end
        @(negedge clk);
        cpu_req = 1'b0; bus_done = 1'b0; bus_gnt = 1'b0; bus_shared = 1'b0; snp_op = 2'b00;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "WATCHDOG", "timeout", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(!cpu_ack && !cpu_stall && !bus_req, "R1", "idle after reset", int'({cpu_ack, cpu_stall, bus_req}), 0);
        probe(1, 9'h015, "R1");                   // empty cache: no response
        probe(2, 9'h1F3, "R1");
        // R2 read miss, nobody else holds -> Exclusive
        cpu_op(0, 9'h011, 0, 2, 0, "R2");
        cpu_op(0, 9'h011, 0, 0, 0, "R3");         // read hit on E
        cpu_op(1, 9'h011, 0, 0, 0, "R6");         // silent E -> M
        cpu_op(1, 9'h011, 0, 0, 0, "R6");         // M stays M
        cpu_op(0, 9'h011, 0, 0, 0, "R3");
        probe(1, 9'h011, "R7");                   // M supplies, writes back, -> S
        probe(1, 9'h011, "R7");                   // S just reports shared
        cpu_op(0, 9'h011, 0, 0, 0, "R3");         // read hit on S
        cpu_op(1, 9'h011, 0, 1, 0, "R5");         // S -> invalidate -> M
        probe(2, 9'h011, "R8");                   // M supplies then Invalid
        probe(1, 9'h011, "R8");                   // gone
        // R2 read miss with others holding -> Shared
        cpu_op(0, 9'h022, 0, 0, 1, "R2");
        probe(1, 9'h022, "R2");
        probe(3, 9'h022, "R9");                   // invalidate drops S
        probe(1, 9'h022, "R9");
        // R4 write miss -> RFO -> M
        cpu_op(1, 9'h033, 0, 3, 1, "R4");
        probe(1, 9'h033, "R4");
        // E then snooped RFO -> Invalid, no supply
        cpu_op(0, 9'h044, 0, 0, 0, "R2");
        probe(2, 9'h044, "R8");
        probe(1, 9'h044, "R8");
        // R11 pending invalidate turned into RFO by a colliding snoop
        cpu_op(0, 9'h055, 0, 0, 1, "R11");
        cpu_op(1, 9'h055, 2, 1, 0, "R11");
        probe(1, 9'h055, "R11");
        // R11 write hit on E stalled by a colliding snooped read, then invalidates
        cpu_op(0, 9'h066, 0, 0, 0, "R11");
        cpu_op(1, 9'h066, 1, 0, 0, "R11");
        probe(1, 9'h066, "R11");
        // R12 same index, different tag
        cpu_op(0, 9'h017, 0, 0, 0, "R12");
        cpu_op(0, 9'h0A7, 0, 0, 0, "R12");        // miss despite valid index
        probe(1, 9'h017, "R12");
        probe(1, 9'h0A7, "R12");
        // R10 long wait for grant on a write miss
        cpu_op(1, 9'h1C2, 0, 6, 0, "R10");
        probe(2, 9'h1C2, "R10");
        // snoop to non-matching tag at held index leaves line alone
        cpu_op(0, 9'h0B1, 0, 0, 0, "R12");
        probe(2, 9'h131, "R12");
        probe(1, 9'h0B1, "R12");
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule